// File: doc/BRIEF.md
# Two-by-two self-routing packet switch

This block is one switching element of a multistage interconnect. It has two input links and two output links. Each carries one beat per cycle under a valid/ready handshake, with a head marker on the first beat of a packet and a last marker on the final beat. A packet is a header beat, zero or more payload beats, and a trailer beat that holds a checksum. A packet made of a single beat carrying both markers is also accepted. The header beat carries the destination in its low `DEST_W` bits. The top bit of that field picks the output link. That bit is then cleared in the forwarded header, so the next stage, built with a destination one bit narrower, reads only the remaining bits.

Each output has a lock controller with two states. `ST_IDLE` means the output is free. `ST_HOLD` means the output belongs to one input until that input's trailer passes. A free output that can take a beat grants a requesting header. If the beat is not marked last, the controller moves `ST_IDLE -> ST_HOLD`. A single-beat packet keeps it in `ST_IDLE`. When the owner's last beat is granted, the controller returns `ST_HOLD -> ST_IDLE`. When both inputs ask for the same free output, a per-output rotating priority bit picks the winner. Every output beat passes through one register stage, and that stage holds its beat while the receiver stalls.

Top module: `bfly_switch2x2`

## Requirements
- R1: A header beat whose destination top bit (bit `DEST_W-1` of the data) is 0 leaves on output 0, and one whose top bit is 1 leaves on output 1.
- R2: On a forwarded header beat, bit `DEST_W-1` reads 0 and every other data bit equals the input header.
- R3: Payload and trailer beats leave unchanged, together with their head and last markers. A beat accepted at one rising edge is valid at the output from that edge on.
- R4: Once a header is granted, its output takes beats only from the same input until that input's last beat has been granted. A header from the other input aimed at that output sees ready low meanwhile.
- R5: When both inputs present headers for the same free output, the input named by that output's priority bit wins. Priority starts at input 0 after reset, and after each granted header it passes to the input that did not win.
- R6: An input that is not granted sees ready low. Every beat offered is delivered exactly once, in order within its packet.
- R7: Packets from the two inputs to different outputs flow at the same time.
- R8: While an output is valid and its ready is low, that output's beat and markers stay unchanged.
- R9: During reset both outputs are invalid, and both controllers start in `ST_IDLE` with priority on input 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Beat offered on each input |
| in_ready | output | 2 | Beat taken from each input this cycle |
| in_head | input | 2 | First beat of a packet, per input |
| in_last | input | 2 | Final beat of a packet, per input |
| in_data | input | 2 x DATA_W | Beat data per input; destination in the low DEST_W bits of a header |
| out_valid | output | 2 | Beat present on each output |
| out_ready | input | 2 | Receiver takes the output beat |
| out_head | output | 2 | Head marker of the output beat |
| out_last | output | 2 | Last marker of the output beat |
| out_data | output | 2 x DATA_W | Output beat data; destination top bit cleared on headers |

## Verification
A lock controller stuck in `ST_HOLD` blocks every later header for that output, so its input's ready stays low from the next cycle on. A lock released too early lets the other input's header slip in, and mixed beats appear on the output one cycle after the grant. A wrong priority bit shows up at the first conflicting pair of headers as the opposite ready pattern. A broken output register shows as changed data while ready is low, or as a repeated or missing beat on the cycle after a handshake. The bench model predicts ready and every output field each cycle, so any of these faults is reported within one clock.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
    // Lock state of one output link
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } lock_state_e;
endpackage

// File: rtl/bfly_out_ctrl.sv
module bfly_out_ctrl
    import bfly_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_head,   // valid header beats aimed at this output
    input  logic [1:0] in_valid,
    input  logic [1:0] in_last,
    input  logic       space,      // output register can take a beat
    output logic [1:0] grant,
    output logic       sel
);
    lock_state_e state_q, state_d;
    logic        owner_q, owner_d;
    logic        prio_q, prio_d;
    logic        winner;

    always_comb begin
        grant   = 2'b00;
        winner  = owner_q;
        state_d = state_q;
        owner_d = owner_q;
        prio_d  = prio_q;
        unique case (state_q)
            ST_IDLE: begin
                winner = (req_head == 2'b11) ? prio_q : req_head[1];
                if (req_head != 2'b00 && space) begin
                    grant[winner] = 1'b1;
                    prio_d        = ~winner;
                    owner_d       = winner;
                    if (!in_last[winner]) state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (in_valid[owner_q] && space) begin
                    grant[owner_q] = 1'b1;
                    if (in_last[owner_q]) state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign sel = winner;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= 1'b0;
            prio_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            prio_q  <= prio_d;
        end
    end

    // R4: a held output never serves the non-owner
    a_r4_hold_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !grant[~owner_q]);

    // R4: the lock persists until the owner's last beat is granted
    a_r4_lock_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !(grant[owner_q] && in_last[owner_q]))
        |=> (state_q == ST_HOLD && $stable(owner_q)));

    // R5: a conflict on a free output goes to the priority input
    a_r5_conflict_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_head == 2'b11 && space) |-> grant[prio_q]);

    // R6: at most one input is served per cycle
    a_r6_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: rtl/bfly_beat_reg.sv
module bfly_beat_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d_data,
    input  logic              d_head,
    input  logic              d_last,
    input  logic              out_ready,
    output logic              space,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_head,
    output logic              out_last
);
    assign space = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_head  <= 1'b0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= d_data;
            out_head  <= d_head;
            out_last  <= d_last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R8: a stalled beat stays put
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_data) && $stable(out_head) && $stable(out_last)));

    // R6: a beat is never written over an unaccepted one
    a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> space);
endmodule

// File: rtl/bfly_switch2x2.sv
module bfly_switch2x2 #(
    parameter int DATA_W = 16,
    parameter int DEST_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             in_valid,
    output logic [1:0]             in_ready,
    input  logic [1:0]             in_head,
    input  logic [1:0]             in_last,
    input  logic [1:0][DATA_W-1:0] in_data,
    output logic [1:0]             out_valid,
    input  logic [1:0]             out_ready,
    output logic [1:0]             out_head,
    output logic [1:0]             out_last,
    output logic [1:0][DATA_W-1:0] out_data
);
    localparam int RBIT = DEST_W - 1;

    logic [1:0][DATA_W-1:0] fwd_data;
    logic [1:0]             route;
    logic [1:0][1:0]        grant;
    logic [1:0]             sel;
    logic [1:0]             space;

    for (genvar i = 0; i < 2; i++) begin : g_in
        assign route[i] = in_data[i][RBIT];
        always_comb begin
            fwd_data[i] = in_data[i];
            if (in_head[i]) fwd_data[i][RBIT] = 1'b0;
        end
        assign in_ready[i] = grant[0][i] | grant[1][i];

        // R6: a beat is routed to one output only
        a_r6_single_route: assert property (@(posedge clk) disable iff (!rst_n)
            !(grant[0][i] && grant[1][i]));
    end

    for (genvar o = 0; o < 2; o++) begin : g_out
        logic [1:0] req_head;
        for (genvar i = 0; i < 2; i++) begin : g_req
            assign req_head[i] = in_valid[i] && in_head[i] && (route[i] == 1'(o));

            // R1, R2: an accepted header appears on its output, top bit cleared
            a_r1_steer: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid[i] && in_ready[i] && in_head[i] && route[i] == 1'(o))
                |=> (out_valid[o] && out_head[o] && !out_data[o][RBIT]));
        end

        bfly_out_ctrl u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_head (req_head),
            .in_valid (in_valid),
            .in_last  (in_last),
            .space    (space[o]),
            .grant    (grant[o]),
            .sel      (sel[o])
        );

        bfly_beat_reg #(.DATA_W(DATA_W)) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (|grant[o]),
            .d_data    (fwd_data[sel[o]]),
            .d_head    (in_head[sel[o]]),
            .d_last    (in_last[sel[o]]),
            .out_ready (out_ready[o]),
            .space     (space[o]),
            .out_valid (out_valid[o]),
            .out_data  (out_data[o]),
            .out_head  (out_head[o]),
            .out_last  (out_last[o])
        );
    end
endmodule

// File: tb/bfly_switch2x2_tb.sv
module bfly_switch2x2_tb;
    localparam int DW  = 16;
    localparam int DST = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] in_valid = '0, in_head = '0, in_last = '0, out_ready = '0;
    logic [1:0][DW-1:0] in_data = '0;
    logic [1:0] in_ready, out_valid, out_head, out_last;
    logic [1:0][DW-1:0] out_data;

    always #5 clk = ~clk;

    bfly_switch2x2 #(.DATA_W(DW), .DEST_W(DST)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_head(in_head),
        .in_last(in_last), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_head(out_head),
        .out_last(out_last), .out_data(out_data)
    );

    int checks = 0, errors = 0;
    int sent = 0, got = 0;
    logic [DW+1:0] qa[$], qb[$];       // {head, last, data}
    int owner[2], prio[2];
    bit mv[2], mh[2], ml[2], stalled[2];
    logic [DW-1:0] md[2];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic push(input int src, input logic [DW+1:0] b);
        if (src == 0) qa.push_back(b); else qb.push_back(b);
        sent++;
    endtask

    task automatic add_pkt(input int src, input int dbit, input int plen);
        logic [DW-1:0] h = DW'($urandom);
        h[DST-1] = dbit[0];
        push(src, {2'b10, h});
        for (int k = 0; k < plen; k++) push(src, {2'b00, DW'($urandom)});
        push(src, {2'b01, DW'($urandom)});
    endtask

    task automatic present(input int i, input int gap);
        logic [DW+1:0] b;
        if (in_valid[i]) return;
        if (i == 0 && qa.size() == 0) return;
        if (i == 1 && qb.size() == 0) return;
        if (int'($urandom % 100) < gap) return;
        b = (i == 0) ? qa[0] : qb[0];
        in_valid[i] = 1'b1;
        in_head[i]  = b[DW+1];
        in_last[i]  = b[DW];
        in_data[i]  = b[DW-1:0];
    endtask

    task automatic step(input int gap, input int rdy);
        int g[2];
        bit conflict;
        bit [1:0] exp_rdy;
        string tag;
        @(negedge clk);
        conflict = 1'b0;
        for (int o = 0; o < 2; o++) begin
            bit sp = !mv[o] || out_ready[o];
            g[o] = -1;
            if (owner[o] < 0) begin
                bit r0 = in_valid[0] && in_head[0] && (int'(in_data[0][DST-1]) == o);
                bit r1 = in_valid[1] && in_head[1] && (int'(in_data[1][DST-1]) == o);
                int w = (r0 && r1) ? prio[o] : r0 ? 0 : r1 ? 1 : -1;
                if (r0 && r1) conflict = 1'b1;
                if (w >= 0 && sp) g[o] = w;
            end else if (in_valid[owner[o]] && sp) begin
                g[o] = owner[o];
            end
        end
        for (int i = 0; i < 2; i++) begin
            exp_rdy[i] = (g[0] == i) || (g[1] == i);
            tag = conflict ? "R5" : (owner[0] >= 0 || owner[1] >= 0) ? "R4" : "R6";
            chk(in_ready[i] == exp_rdy[i], tag, 32'(in_ready[i]), 32'(exp_rdy[i]));
        end
        for (int o = 0; o < 2; o++) begin
            tag = (mv[0] && mv[1]) ? "R7" : "R1";
            chk(out_valid[o] == mv[o], tag, 32'(out_valid[o]), 32'(mv[o]));
            if (mv[o]) begin
                tag = stalled[o] ? "R8" : mh[o] ? "R2" : "R3";
                chk({out_head[o], out_last[o], out_data[o]} == {mh[o], ml[o], md[o]}, tag,
                    32'({out_head[o], out_last[o], out_data[o]}), 32'({mh[o], ml[o], md[o]}));
                if (out_ready[o]) got++;
            end
        end
        // advance the model to the state after the coming edge
        for (int o = 0; o < 2; o++) begin
            if (g[o] >= 0) begin
                int w = g[o];
                mv[o] = 1'b1; mh[o] = in_head[w]; ml[o] = in_last[w];
                md[o] = in_data[w];
                if (in_head[w]) md[o][DST-1] = 1'b0;
                stalled[o] = 1'b0;
                if (owner[o] < 0) begin
                    prio[o] = 1 - w;
                    if (!in_last[w]) owner[o] = w;
                end else if (in_last[w]) begin
                    owner[o] = -1;
                end
            end else begin
                stalled[o] = mv[o] && !out_ready[o];
                if (out_ready[o]) mv[o] = 1'b0;
            end
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < 2; i++) begin
            if (exp_rdy[i]) begin
                if (i == 0) void'(qa.pop_front()); else void'(qb.pop_front());
                in_valid[i] = 1'b0;
            end
            present(i, gap);
            out_ready[i] = (int'($urandom % 100) < rdy);
        end
    endtask

    task automatic run(input int gap, input int rdy);
        int n = 0;
        while ((qa.size() != 0 || qb.size() != 0 || mv[0] || mv[1] || in_valid != 0) && n < 20000) begin
            step(gap, rdy);
            n++;
        end
        repeat (3) step(gap, 100);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R6: watchdog expired, actual 0 expected 1 (run complete)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        for (int o = 0; o < 2; o++) begin
            owner[o] = -1; prio[o] = 0; mv[o] = 0; stalled[o] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: outputs idle while reset is held
        chk(out_valid == 2'b00, "R9", 32'(out_valid), 32'h0);
        chk(in_ready == 2'b00, "R9", 32'(in_ready), 32'h0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // directed: conflict on output 1, then concurrent traffic (R5, R4, R7)
        add_pkt(0, 1, 2);
        add_pkt(1, 1, 2);
        add_pkt(0, 0, 3);
        add_pkt(1, 1, 1);
        add_pkt(0, 1, 0);
        add_pkt(1, 1, 0);
        out_ready = 2'b11;
        present(0, 0);
        present(1, 0);
        run(0, 100);

        // random traffic with gaps and moderate backpressure (R1, R2, R3, R6)
        for (int k = 0; k < 60; k++) begin
            add_pkt(0, int'($urandom % 2), int'($urandom % 4));
            add_pkt(1, int'($urandom % 2), int'($urandom % 4));
        end
        run(30, 70);

        // heavy stalls (R8) and dense headers
        for (int k = 0; k < 30; k++) begin
            add_pkt(0, int'($urandom % 2), int'($urandom % 3));
            add_pkt(1, int'($urandom % 2), int'($urandom % 3));
        end
        run(0, 30);

        // R6: every beat offered came out exactly once
        chk(qa.size() == 0 && qb.size() == 0, "R6", 32'(qa.size() + qb.size()), 32'h0);
        chk(got == sent, "R6", 32'(got), 32'(sent));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule